// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Spiking Neuron

This block models one spiking neuron with a signed fixed-point membrane potential. In each clock cycle where a valid input current arrives and the neuron is free to integrate, the potential first loses a fraction of itself: the potential shifted arithmetically right by a leak parameter. The input current is then added, and the result saturates at the signed limits of the potential word. When that updated value reaches a signed threshold, the neuron raises a spike flag for exactly one cycle. In that same cycle it reports a potential of zero.

After a spike the neuron stays silent for a refractory window. The window length is a parameter, capped by a second parameter. During the window the potential stays at zero, and arriving currents are dropped. The cycle in which the spike is shown also drops its input.

The potential is a 16-bit word with 8 fractional bits by default. Threshold, leak shift, refractory length and its cap are elaboration-time parameters. A leak shift of zero selects a variant with no leak.

Top module: `lif_spike_unit`

## Requirements
- R1: Reset is synchronous and active low. At the first edge where reset is sampled low, `potential` becomes 0 and `spike` becomes 0. Any refractory state is cleared, so the first valid input after reset is integrated at once.
- R2: When the neuron is free (not spiking, not refractory) and `in_valid` is 1, the next potential is P - (P >>> LEAK_SHIFT) + I. For a LEAK_SHIFT of 0 it is P + I. Here P is the present potential and I is `in_current`, both two's-complement and sharing one fixed-point scale.
- R3: The sum of R2 saturates. A value above 32767 becomes 32767, and a value below -32768 becomes -32768, for the default 16-bit width.
- R4: If the updated potential is greater than or equal to the signed THRESHOLD, `spike` is 1 in the next cycle and `potential` is 0 in that same cycle.
- R5: After the spike cycle, `spike` stays 0 and `potential` stays 0 for min(REFRACT_LEN, REFRACT_MAX) cycles. Valid inputs that arrive during those cycles are not accumulated.
- R6: When the neuron is free and `in_valid` is 0, `potential` keeps its value and `spike` is 0.
- R7: A spike never lasts more than one cycle. The input presented in the spike cycle is discarded. The internal refractory count never exceeds REFRACT_MAX (default 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input current is present this cycle |
| in_current | input | POT_W (16) | Signed input current, same scale as the potential |
| spike | output | 1 | One-cycle spike flag |
| potential | output | POT_W (16) | Signed membrane potential |

## Verification
Positive saturation is the hardest case to reach from the ports. With a normal threshold the neuron fires long before the sum can overflow, so the clamp at the top is never exercised. The bench therefore drives a second instance whose threshold equals the largest positive value and which has no leak. Large currents then push its sum past the limit, and the clamped value is exactly what triggers the spike. The same instance asks for a refractory length above the cap, so the cap shows up at the ports as a window of exactly three silent cycles.

// File: rtl/lif_pkg.sv
package lif_pkg;

   // Effective refractory load: requested length limited by the cap
   function automatic int cap_len(input int req_len, input int max_len);
      return (req_len > max_len) ? max_len : req_len;
   endfunction

   // Counter width able to hold 0..max_len
   function automatic int cnt_width(input int max_len);
      return (max_len < 2) ? 1 : $clog2(max_len + 1);
   endfunction

endpackage

// File: rtl/lif_integrator.sv
module lif_integrator #(
   parameter int                      POT_W      = 16,
   parameter int                      LEAK_SHIFT = 2,
   parameter logic signed [POT_W-1:0] THRESHOLD  = 16'sh0100
) (
   input  logic signed [POT_W-1:0] pot,
   input  logic signed [POT_W-1:0] cur,
   output logic signed [POT_W-1:0] nxt,
   output logic                    fire
);
   localparam int SUM_W = POT_W + 2;
   localparam logic signed [SUM_W-1:0] SAT_HI = {{3{1'b0}}, {(POT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] SAT_LO = {{3{1'b1}}, {(POT_W-1){1'b0}}};

   logic signed [POT_W-1:0] leak;
   logic signed [SUM_W-1:0] sum;

   generate
      if (LEAK_SHIFT < 0 || LEAK_SHIFT >= POT_W) begin : g_bad_shift
         $error("lif_integrator: LEAK_SHIFT out of range");
      end
      if (LEAK_SHIFT == 0) begin : g_no_leak
         assign leak = '0;
      end else begin : g_leak
         assign leak = pot >>> LEAK_SHIFT;
      end
   endgenerate

   assign sum = {{2{pot[POT_W-1]}}, pot}
              - {{2{leak[POT_W-1]}}, leak}
              + {{2{cur[POT_W-1]}}, cur};

   always_comb begin
      if (sum > SAT_HI)      nxt = SAT_HI[POT_W-1:0];
      else if (sum < SAT_LO) nxt = SAT_LO[POT_W-1:0];
      else                   nxt = sum[POT_W-1:0];
   end

   assign fire = (nxt >= THRESHOLD);

   // R3
   always_comb begin
      saturation_range_chk: assert (!((sum > SAT_HI) && (nxt != SAT_HI[POT_W-1:0]))
                                    && !((sum < SAT_LO) && (nxt != SAT_LO[POT_W-1:0])));
   end
endmodule

// File: rtl/lif_refractory.sv
module lif_refractory #(
   parameter int REFRACT_LEN = 2,
   parameter int REFRACT_MAX = 3,
   localparam int CNT_W = lif_pkg::cnt_width(REFRACT_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [CNT_W-1:0] count
);
   localparam int LOAD = lif_pkg::cap_len(REFRACT_LEN, REFRACT_MAX);

   generate
      if (REFRACT_MAX < 1) begin : g_bad_max
         $error("lif_refractory: REFRACT_MAX must be at least 1");
      end
      if (REFRACT_LEN < 0) begin : g_bad_len
         $error("lif_refractory: REFRACT_LEN must not be negative");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           count <= '0;
      else if (start)       count <= CNT_W'(LOAD);
      else if (count != '0) count <= count - CNT_W'(1);
   end

   assign busy = (count != '0);

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(REFRACT_MAX));

   // R5
   cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/lif_spike_unit.sv
module lif_spike_unit #(
   parameter int                      POT_W       = 16,
   parameter int                      FRAC_W      = 8,
   parameter logic signed [POT_W-1:0] THRESHOLD   = 16'sh0100,
   parameter int                      LEAK_SHIFT  = 2,
   parameter int                      REFRACT_LEN = 2,
   parameter int                      REFRACT_MAX = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [POT_W-1:0] in_current,
   output logic                    spike,
   output logic signed [POT_W-1:0] potential
);
   localparam int CNT_W = lif_pkg::cnt_width(REFRACT_MAX);

   generate
      if (POT_W < 4) begin : g_bad_width
         $error("lif_spike_unit: POT_W too small");
      end
      if (FRAC_W < 0 || FRAC_W >= POT_W) begin : g_bad_frac
         $error("lif_spike_unit: FRAC_W must leave an integer sign bit");
      end
   endgenerate

   logic signed [POT_W-1:0] nxt_pot;
   logic                    fire;
   logic                    refr_busy;
   logic [CNT_W-1:0]        refr_count;
   logic                    free;

   lif_integrator #(
      .POT_W      (POT_W),
      .LEAK_SHIFT (LEAK_SHIFT),
      .THRESHOLD  (THRESHOLD)
   ) u_integ (
      .pot  (potential),
      .cur  (in_current),
      .nxt  (nxt_pot),
      .fire (fire)
   );

   lif_refractory #(
      .REFRACT_LEN (REFRACT_LEN),
      .REFRACT_MAX (REFRACT_MAX)
   ) u_refr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (spike),
      .busy  (refr_busy),
      .count (refr_count)
   );

   // The spike cycle itself also counts as closed to input
   assign free = !spike && !refr_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         potential <= '0;
         spike     <= 1'b0;
      end else if (!free) begin
         potential <= '0;
         spike     <= 1'b0;
      end else if (in_valid) begin
         if (fire) begin
            potential <= '0;
            spike     <= 1'b1;
         end else begin
            potential <= nxt_pot;
            spike     <= 1'b0;
         end
      end else begin
         spike <= 1'b0;
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (potential == '0 && !spike && refr_count == '0));

   // R4
   spike_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> (potential == '0));

   // R5
   refr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refr_busy |-> (!spike && potential == '0));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free && !in_valid) |=> ($stable(potential) && !spike));

   // R7
   spike_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spike |=> !spike);
endmodule

// File: tb/lif_spike_unit_test.sv
module lif_spike_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int POT_MAX = 32767;
   localparam int POT_MIN = -32768;
   localparam int WATCHDOG = 20000;

   // config 0: uut (defaults); config 1: uut_alt (no leak, top threshold, capped length)
   localparam int SHIFT [2] = '{2, 0};
   localparam int THRESH[2] = '{256, 32767};
   localparam int LOADN [2] = '{2, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_current = '0;
   logic spk0, spk1;
   logic signed [15:0] pot0, pot1;

   int checks = 0;
   int errors = 0;
   bit timeout = 1'b0;
   int m_pot[2];
   bit m_spk[2];
   int m_cnt[2];

   always #(CLK_PERIOD/2) clk = ~clk;

   lif_spike_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_current(in_current),
      .spike(spk0), .potential(pot0));

   lif_spike_unit #(.THRESHOLD(16'sh7FFF), .LEAK_SHIFT(0), .REFRACT_LEN(7), .REFRACT_MAX(3)) uut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_current(in_current),
      .spike(spk1), .potential(pot1));

   task automatic check(string tag, int k, int act_p, int exp_p, bit act_s, bit exp_s);
      checks++;
      if (act_p != exp_p || act_s != exp_s) begin
         errors++;
         $display("FAIL %s inst%0d: potential=%0d spike=%0b expected potential=%0d spike=%0b",
                  tag, k, act_p, exp_p, act_s, exp_s);
      end
   endtask

   task automatic cycle(bit v, int c, bit rst);
      string tag[2];
      rst_n      = ~rst;
      in_valid   = v;
      in_current = 16'(c);
      for (int k = 0; k < 2; k++) begin
         if (rst) begin
            tag[k] = "R1"; m_pot[k] = 0; m_spk[k] = 0; m_cnt[k] = 0;
         end else if (m_spk[k] || m_cnt[k] != 0) begin
            tag[k] = m_spk[k] ? "R7" : "R5";
            m_cnt[k] = m_spk[k] ? LOADN[k] : m_cnt[k] - 1;
            m_pot[k] = 0; m_spk[k] = 0;
         end else if (!v) begin
            tag[k] = "R6"; m_spk[k] = 0;
         end else begin
            int n;
            n = m_pot[k] - ((SHIFT[k] == 0) ? 0 : (m_pot[k] >>> SHIFT[k])) + c;
            tag[k] = "R2";
            if (n > POT_MAX) begin n = POT_MAX; tag[k] = "R3"; end
            if (n < POT_MIN) begin n = POT_MIN; tag[k] = "R3"; end
            if (n >= THRESH[k]) begin
               m_spk[k] = 1; m_pot[k] = 0;
               if (tag[k] != "R3") tag[k] = "R4";
            end else begin
               m_spk[k] = 0; m_pot[k] = n;
            end
         end
      end
      @(posedge clk);
      #1;
      check(tag[0], 0, int'(pot0), m_pot[0], spk0, m_spk[0]);
      check(tag[1], 1, int'(pot1), m_pot[1], spk1, m_spk[1]);
   endtask

   task automatic run_all();
      // R1: reset with a large valid input present
      for (int i = 0; i < 3; i++) cycle(1'b1, 5000, 1'b1);
      // R2/R4: constant-current sweep, both signs
      for (int c = -640; c <= 640; c += 40) begin
         cycle(1'b0, 0, 1'b1);
         for (int s = 0; s < 8; s++) cycle(1'b1, c, 1'b0);
      end
      // R6: valid strobe gaps
      for (int c = 100; c <= 700; c += 75) begin
         cycle(1'b0, 0, 1'b1);
         for (int s = 0; s < 12; s++) cycle((s % 3) != 0, c, 1'b0);
      end
      // R3: negative then positive saturation
      cycle(1'b0, 0, 1'b1);
      for (int s = 0; s < 6; s++) cycle(1'b1, -32768, 1'b0);
      for (int s = 0; s < 6; s++) cycle(1'b1, 32767, 1'b0);
      for (int s = 0; s < 6; s++) cycle(1'b1, 20000, 1'b0);
      // R5/R7: repeated firing, inputs during refractory dropped
      cycle(1'b0, 0, 1'b1);
      for (int s = 0; s < 12; s++) cycle(1'b1, 1000, 1'b0);
      // R1: reset in the middle of refractory clears it
      cycle(1'b0, 0, 1'b1);
      cycle(1'b1, 1000, 1'b0);
      cycle(1'b1, 1000, 1'b1);
      for (int s = 0; s < 4; s++) cycle(1'b1, 100, 1'b0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=expired expected=done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule